// File: doc/BRIEF.md
# Charge Enable and Watchdog Supervisor

This block decides, every clock cycle, whether the battery charger's switching controller may run, and which charge-current code the current regulation loop is given. It sits behind the serial-bus register block. That block hands it a write strobe and a 16-bit data word for the charge-voltage setting and for the charge-current setting. It also watches four status lines: the battery-select input, a low-battery comparator, a power-fail comparator and the logic-supply under-voltage flag.

Charging is armed only once both settings have been written since the last reset or timeout. A long command watchdog disarms the charger when no setting write arrives for a full interval. A toggle of the battery-select line halts charging at once and holds it off for a short restart pause. While the cell is deeply discharged, the current code passed on is forced down to the lowest step, and the stored setting is kept for later use. All intervals are counted in ticks of a parameterised prescaler, so a test can shorten them.

Top module: `charge_supervisor`

## Requirements
- R1: After `rst_n` is released, `chg_en` is 0 and `ichg_code` is 0.
- R2: `chg_en` can rise only after both a voltage-setting write and a current-setting write have been accepted since the last reset, supply clear or watchdog expiry. One of the two on its own never enables charging.
- R3: The voltage code is `vset_data[14:4]`, at 16 mV per step. A code below 64 (under 1024 mV) forces `chg_en` low. Bits 15 and 3:0 are ignored.
- R4: The current code is `iset_data[12:7]`, at 128 mA per step. A code of 0 forces `chg_en` low. Bits 15:13 and 6:0 are ignored. When `bat_low` is 0, `ichg_code` equals the stored code one cycle after the write.
- R5: While `bat_low` is 1 and the stored current code is non-zero, `ichg_code` is 1 (128 mA). The stored code is kept and reappears the cycle after `bat_low` returns to 0.
- R6: While `pwr_fail` is 1, `chg_en` is 0 from the next cycle onward.
- R7: Any change of `bat_sel` drives `chg_en` to 0 on the next clock edge. Charging may resume only after `HOLD_TICKS` prescaler ticks have elapsed.
- R8: When `WDOG_TICKS` ticks pass with no setting write, `chg_en` falls and both settings must be written again before it can rise.
- R9: Every accepted setting write restarts the watchdog. This includes a write whose value itself stops charging.
- R10: While `vdd_low` is 1, all state returns to its reset value: `chg_en` is 0, `ichg_code` is 0, and both settings are forgotten.
- R11: When a setting write that completes arming lands in the same cycle as a `bat_sel` change, the write is kept but the restart pause still applies. Charging begins only after the pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vdd_low | input | 1 | Logic supply below power-on level; clears all state |
| vset_wr | input | 1 | One-cycle strobe: voltage-setting word accepted |
| vset_data | input | 16 | Voltage-setting word |
| iset_wr | input | 1 | One-cycle strobe: current-setting word accepted |
| iset_data | input | 16 | Current-setting word |
| bat_sel | input | 1 | Battery-select line |
| bat_low | input | 1 | Cell voltage below the deep-discharge threshold |
| pwr_fail | input | 1 | Input sense within 10 mV of output sense |
| chg_en | output | 1 | Registered charge enable to the switching controller |
| ichg_code | output | 6 | Effective charge-current code, 128 mA per step |

## Verification
The restart pause and the arming rule can be decided in the same cycle. The bench provokes this by toggling `bat_sel` on the same edge as the current-setting write that completes arming. It then judges that `chg_en` stays low for the whole pause and rises afterwards without a further write. The bench also checks the watchdog restart by a disabling write. It spaces two writes so that only the restart keeps the charger armed. Randomly timed setting writes, low-battery and power-fail levels are compared each cycle against a bench model of the enable and current code.

// File: rtl/charge_sup_pkg.sv
package charge_sup_pkg;
    // Field positions decoded from the setting words
    localparam int VFLD_LSB  = 4;
    localparam int VFLD_W    = 11;
    localparam int IFLD_LSB  = 7;
    localparam int IFLD_W    = 6;
    // Smallest voltage code that still requests charging (1024 mV / 16 mV)
    localparam int VCODE_MIN = 64;
    // Lowest current step used while the cell is deeply discharged
    localparam logic [IFLD_W-1:0] FOLD_CODE = IFLD_W'(1);

    typedef logic [VFLD_W-1:0] vcode_t;
    typedef logic [IFLD_W-1:0] icode_t;

    typedef struct packed {
        logic   vseen;
        logic   iseen;
        vcode_t vcode;
        icode_t icode;
        logic   sel_prev;
        logic   en;
        icode_t ieff;
    } sup_state_t;
endpackage

// File: rtl/cs_tick_gen.sv
module cs_tick_gen #(
    parameter int DIV = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tick;
    } tg_state_t;

    tg_state_t tg_q, tg_d;

    always_comb begin
        tg_d      = tg_q;
        tg_d.tick = 1'b0;
        if (tg_q.cnt == CW'(DIV - 1)) begin
            tg_d.cnt  = '0;
            tg_d.tick = 1'b1;
        end else begin
            tg_d.cnt = tg_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tg_q <= '0;
        else        tg_q <= tg_d;
    end

    assign tick = tg_q.tick;
endmodule

// File: rtl/cs_interval_timer.sv
module cs_interval_timer #(
    parameter int LIMIT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic start,
    input  logic tick,
    output logic busy,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          busy;
        logic          expired;
    } it_state_t;

    it_state_t it_q, it_d;

    always_comb begin
        it_d         = it_q;
        it_d.expired = 1'b0;
        if (clr) begin
            it_d = '0;
        end else if (start) begin
            it_d.cnt  = CW'(LIMIT);
            it_d.busy = 1'b1;
        end else if (it_q.busy && tick) begin
            if (it_q.cnt == CW'(1)) begin
                it_d.cnt     = '0;
                it_d.busy    = 1'b0;
                it_d.expired = 1'b1;
            end else begin
                it_d.cnt = it_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) it_q <= '0;
        else        it_q <= it_d;
    end

    assign busy    = it_q.busy;
    assign expired = it_q.expired;
endmodule

// File: rtl/charge_supervisor.sv
module charge_supervisor
    import charge_sup_pkg::*;
#(
    parameter int TICK_DIV   = 1000,
    parameter int WDOG_TICKS = 175000,
    parameter int HOLD_TICKS = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        vdd_low,
    input  logic        vset_wr,
    input  logic [15:0] vset_data,
    input  logic        iset_wr,
    input  logic [15:0] iset_data,
    input  logic        bat_sel,
    input  logic        bat_low,
    input  logic        pwr_fail,
    output logic        chg_en,
    output logic [5:0]  ichg_code
);
    sup_state_t st_q, st_d;

    logic tick;
    logic wd_busy, wd_exp;
    logic hold_busy, hold_exp;
    logic sel_chg, wr_any;

    assign sel_chg = (bat_sel != st_q.sel_prev);
    assign wr_any  = vset_wr | iset_wr;

    cs_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    // Command watchdog: restarted by every accepted setting write (R9)
    cs_interval_timer #(.LIMIT(WDOG_TICKS)) u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (vdd_low),
        .start   (wr_any),
        .tick    (tick),
        .busy    (wd_busy),
        .expired (wd_exp)
    );

    // Restart pause after a battery-select change (R7)
    cs_interval_timer #(.LIMIT(HOLD_TICKS)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (vdd_low),
        .start   (sel_chg),
        .tick    (tick),
        .busy    (hold_busy),
        .expired (hold_exp)
    );

    always_comb begin
        logic vok, iok;
        st_d          = st_q;
        st_d.sel_prev = bat_sel;

        if (vset_wr) st_d.vcode = vset_data[VFLD_LSB +: VFLD_W];
        if (iset_wr) st_d.icode = iset_data[IFLD_LSB +: IFLD_W];

        // A write in the expiry cycle wins over the expiry
        st_d.vseen = vset_wr | (st_q.vseen & ~wd_exp);
        st_d.iseen = iset_wr | (st_q.iseen & ~wd_exp);

        if (vdd_low) begin
            st_d          = '0;
            st_d.sel_prev = bat_sel;
        end

        vok = (st_d.vcode >= vcode_t'(VCODE_MIN));
        iok = (st_d.icode != '0);

        st_d.en = st_d.vseen & st_d.iseen & vok & iok
                & ~sel_chg & ~hold_busy & ~pwr_fail & ~vdd_low;

        if (vdd_low)
            st_d.ieff = '0;
        else if (bat_low && iok)
            st_d.ieff = FOLD_CODE;
        else
            st_d.ieff = st_d.icode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign chg_en    = st_q.en;
    assign ichg_code = st_q.ieff;
endmodule

// File: rtl/cs_checker.sv
module cs_checker #(
    parameter int TICK_DIV   = 1000,
    parameter int WDOG_TICKS = 175000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       vdd_low,
    input logic       vset_wr,
    input logic       iset_wr,
    input logic       bat_sel,
    input logic       bat_low,
    input logic       pwr_fail,
    input logic       chg_en,
    input logic [5:0] ichg_code
);
    localparam int WD_LIMIT = (WDOG_TICKS + 1) * TICK_DIV + 4;

    logic        past_ok;
    logic        sel_seen;
    logic [31:0] idle_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            past_ok  <= 1'b0;
            sel_seen <= 1'b0;
            idle_cnt <= '0;
        end else begin
            past_ok  <= 1'b1;
            sel_seen <= bat_sel;
            if (vset_wr || iset_wr || vdd_low) idle_cnt <= '0;
            else if (idle_cnt < 32'(WD_LIMIT)) idle_cnt <= idle_cnt + 1'b1;
        end
    end

    // R2: a rising enable was not blocked in the cycle before
    p_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(chg_en)) |-> $past(!pwr_fail && !vdd_low));

    // R5: foldback caps the current code
    p_fold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bat_low |=> (ichg_code <= 6'd1));

    // R6: power fail blocks charging
    p_pwrfail_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> !chg_en);

    // R7: a select change stops charging on the next edge
    p_selchg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bat_sel != sel_seen) |=> !chg_en);

    // R8: no enable after a full watchdog window without writes
    p_wdog_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_cnt >= 32'(WD_LIMIT)) |-> !chg_en);

    // R10: supply under-voltage clears outputs
    p_vdd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        vdd_low |=> (!chg_en && ichg_code == 6'd0));
endmodule

bind charge_supervisor cs_checker #(
    .TICK_DIV   (TICK_DIV),
    .WDOG_TICKS (WDOG_TICKS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .vdd_low   (vdd_low),
    .vset_wr   (vset_wr),
    .iset_wr   (iset_wr),
    .bat_sel   (bat_sel),
    .bat_low   (bat_low),
    .pwr_fail  (pwr_fail),
    .chg_en    (chg_en),
    .ichg_code (ichg_code)
);

// File: tb/charge_supervisor_test.sv
module charge_supervisor_test;
    localparam int CLK_PERIOD = 10;
    localparam int TD = 4;
    localparam int WT = 40;
    localparam int HT = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vdd_low = 1'b0;
    logic        vset_wr = 1'b0;
    logic [15:0] vset_data = '0;
    logic        iset_wr = 1'b0;
    logic [15:0] iset_data = '0;
    logic        bat_sel = 1'b0;
    logic        bat_low = 1'b0;
    logic        pwr_fail = 1'b0;
    logic        chg_en;
    logic [5:0]  ichg_code;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    charge_supervisor #(.TICK_DIV(TD), .WDOG_TICKS(WT), .HOLD_TICKS(HT)) uut (
        .clk(clk), .rst_n(rst_n), .vdd_low(vdd_low),
        .vset_wr(vset_wr), .vset_data(vset_data),
        .iset_wr(iset_wr), .iset_data(iset_data),
        .bat_sel(bat_sel), .bat_low(bat_low), .pwr_fail(pwr_fail),
        .chg_en(chg_en), .ichg_code(ichg_code)
    );

    function automatic logic [15:0] vword(int code, logic [15:0] junk);
        return (16'(code) << 4) | (junk & 16'h800F);
    endfunction

    function automatic logic [15:0] iword(int code, logic [15:0] junk);
        return (16'(code) << 7) | (junk & 16'hE07F);
    endfunction

    function automatic int exp_en(int vc, int ic, bit pf);
        return (vc >= 64 && ic != 0 && !pf) ? 1 : 0;
    endfunction

    function automatic int exp_code(int ic, bit low);
        return (low && ic != 0) ? 1 : ic;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_v(int code, logic [15:0] junk);
        vset_data = vword(code, junk);
        vset_wr = 1'b1;
        @(negedge clk);
        vset_wr = 1'b0;
    endtask

    task automatic wr_i(int code, logic [15:0] junk);
        iset_data = iword(code, junk);
        iset_wr = 1'b1;
        @(negedge clk);
        iset_wr = 1'b0;
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        chk("R1 en", chg_en, 0);
        chk("R1 code", ichg_code, 0);

        // R2 one setting alone
        wr_v(100, 16'h0);
        cyc(1);
        chk("R2 v only", chg_en, 0);
        wr_i(10, 16'h0);
        chk("R2 both", chg_en, 1);
        chk("R4 code", ichg_code, 10);

        // R3 / R4 ignored bits
        wr_v(100, 16'hFFFF);
        chk("R3 junk bits", chg_en, 1);
        wr_i(10, 16'hFFFF);
        chk("R4 junk bits", ichg_code, 10);

        // R3 voltage threshold
        wr_v(63, 16'h0);
        chk("R3 code 63", chg_en, 0);
        wr_v(64, 16'h0);
        chk("R3 code 64", chg_en, 1);

        // R4 zero current
        wr_i(0, 16'h0);
        chk("R4 zero en", chg_en, 0);
        chk("R4 zero code", ichg_code, 0);
        wr_i(5, 16'h0);
        chk("R4 reenable", chg_en, 1);

        // R5 foldback
        bat_low = 1'b1;
        cyc(1);
        chk("R5 folded", ichg_code, 1);
        chk("R5 still en", chg_en, 1);
        bat_low = 1'b0;
        cyc(1);
        chk("R5 restored", ichg_code, 5);

        // R6 power fail
        pwr_fail = 1'b1;
        cyc(1);
        chk("R6 blocked", chg_en, 0);
        pwr_fail = 1'b0;
        cyc(1);
        chk("R6 released", chg_en, 1);

        // R7 select change
        bat_sel = 1'b1;
        cyc(1);
        chk("R7 stop", chg_en, 0);
        cyc((HT - 1) * TD - 1);
        chk("R7 holding", chg_en, 0);
        cyc(TD + 4);
        chk("R7 resumed", chg_en, 1);

        // R8 watchdog
        wr_i(5, 16'h0);
        cyc((WT - 1) * TD - 1);
        chk("R8 before expiry", chg_en, 1);
        cyc(TD + 6);
        chk("R8 expired", chg_en, 0);
        wr_v(100, 16'h0);
        chk("R8 v only again", chg_en, 0);
        wr_i(5, 16'h0);
        chk("R8 rearmed", chg_en, 1);

        // R9 disabling write restarts watchdog
        cyc((WT - 8) * TD);
        wr_v(10, 16'h0);
        chk("R9 disabled", chg_en, 0);
        cyc((WT - 8) * TD);
        wr_v(100, 16'h0);
        chk("R9 still armed", chg_en, 1);

        // R10 supply clear
        vdd_low = 1'b1;
        cyc(1);
        chk("R10 en", chg_en, 0);
        chk("R10 code", ichg_code, 0);
        vdd_low = 1'b0;
        wr_v(100, 16'h0);
        chk("R10 settings lost", chg_en, 0);

        // R11 arming write coincides with select change
        bat_sel = 1'b0;
        wr_i(7, 16'h0);
        chk("R11 held", chg_en, 0);
        cyc((HT - 1) * TD - 1);
        chk("R11 pause", chg_en, 0);
        cyc(TD + 4);
        chk("R11 armed after pause", chg_en, 1);
        chk("R11 code", ichg_code, 7);

        // Random mix of writes, foldback and power fail
        begin
            int vc = 100;
            int ic = 7;
            void'($urandom(32'h5EED1));
            for (int n = 0; n < 300; n++) begin
                bit lw = ($urandom % 3) == 0;
                bit pf = ($urandom % 5) == 0;
                bat_low = lw;
                pwr_fail = pf;
                if ($urandom % 2) begin
                    vc = ($urandom % 4 == 0) ? int'($urandom % 64) : int'($urandom % 2048);
                    wr_v(vc, 16'($urandom));
                end else begin
                    ic = ($urandom % 6 == 0) ? 0 : int'($urandom % 64);
                    wr_i(ic, 16'($urandom));
                end
                chk("R3 R4 R6 random en", chg_en, exp_en(vc, ic, pf));
                chk("R5 random code", ichg_code, exp_code(ic, lw));
            end
        end
        bat_low = 1'b0;
        pwr_fail = 1'b0;
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule